// File: doc/BRIEF.md
# Serial-Flash-Loaded Bus Remapping Table

This block rewrites a parallel data bus through a lookup table held in on-chip RAM. The present data bits and a small control bus together form the table index, and the byte stored at that index is driven onto the output bus one clock later. The transformation has no memory of earlier bus values: each control value picks one complete data-to-data map, and the output depends only on the inputs of the previous cycle.

The table is not built into the FPGA image. After every reset a boot sequencer reads the whole table from an external SPI serial flash in mode 0 and copies it into the RAM. The sequencer sends the standard read command 0x03 and a 24-bit start address of zero, then clocks in one byte per table entry. To change the mapping, only the flash contents are rewritten. While the copy runs, the ready flag is low and the output carries the input data unchanged. When the copy finishes, chip select is released, ready goes high and the lookup path takes over.

The control width is a parameter. The six-bit configuration gives 64 maps and a 16384-entry table. The default of two control bits keeps the elaborated memory small. The SPI clock is the system clock divided by `DIV` (default 4).

Top module: `remap_lut_bridge`

## Requirements
- R1: While reset is high, ready is low, chip select (active low) is high and the SPI clock is low.
- R2: After reset is released, the loader lowers chip select and shifts out 32 bits, MSB first: 0x03 followed by the address 0x000000. MOSI changes only while the SPI clock is low (mode 0).
- R3: The loader then clocks in exactly 2^(CTRL_W+DATA_W) bytes, MSB first, sampled on the rising SPI clock edge. Flash byte N is written to table entry N, where N = {ctrl, din} with ctrl in the upper bits.
- R4: Chip select returns high after the final byte. Ready then rises and stays high until the next reset; while ready is high the SPI clock stays low.
- R5: While ready is low, dout equals the din value of the previous cycle.
- R6: While ready is high, dout equals table entry {ctrl, din} sampled one cycle earlier, including when the inputs change on every cycle.
- R7: The output depends only on the present inputs: the same {ctrl, din} gives the same dout whatever inputs came before.
- R8: During a transfer the SPI clock period is DIV system clocks. The clock idles low whenever chip select is high.
- R9: A reset during a load aborts it. After reset is released, the load starts again with the command and address zero and refills the table from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; restarts the load |
| din | input | DATA_W | Raw data bus |
| ctrl | input | CTRL_W | Raw control bus; selects the map |
| dout | output | DATA_W | Remapped (or passed-through) data, registered |
| ready | output | 1 | High once the table is fully loaded |
| spi_sclk | output | 1 | SPI serial clock, mode 0 |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to flash |
| spi_miso | input | 1 | SPI data from flash |

## Verification
The bench drives the inputs at a falling clock edge and compares dout at the next falling edge. This lands exactly one register stage after the rising edge that captures the inputs, for both the pass-through and the lookup results. The SPI side is checked by a flash model that records the command bits on rising SPI clock edges, counts the edges in each chip-select window and measures their spacing in system cycles. Ready is awaited with a bounded wait, and entries are compared only after it rises. By then the last RAM write has completed.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic [1:0] {
    LD_START,
    LD_CMD,
    LD_DATA,
    LD_DONE
  } ld_state_t;

  localparam logic [7:0] SPI_READ_OP = 8'h03;
  localparam int         HDR_BITS    = 32;
endpackage

// File: rtl/remap_spi_loader.sv
module remap_spi_loader
  import remap_pkg::*;
#(
  parameter int DIV    = 4,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [7:0]        wdata,
  output logic              done
);
  localparam int HALF = DIV / 2;
  localparam int HCW  = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  ld_state_t         st;
  logic [HCW-1:0]    half_cnt;
  logic [HDR_BITS-1:0] tx;
  logic [7:0]        rx;
  logic [4:0]        bitcnt;
  logic [ADDR_W-1:0] baddr;
  logic              edge_tick;

  assign edge_tick = (half_cnt == HCW'(HALF - 1));
  assign mosi      = tx[HDR_BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= LD_START;
      sclk     <= 1'b0;
      cs_n     <= 1'b1;
      half_cnt <= '0;
      tx       <= {SPI_READ_OP, 24'h000000};
      rx       <= '0;
      bitcnt   <= '0;
      baddr    <= '0;
      we       <= 1'b0;
      waddr    <= '0;
      wdata    <= '0;
      done     <= 1'b0;
    end else begin
      we <= 1'b0;
      case (st)
        LD_START: begin
          cs_n     <= 1'b0;
          half_cnt <= '0;
          st       <= LD_CMD;
        end
        LD_CMD, LD_DATA: begin
          if (!edge_tick) begin
            half_cnt <= half_cnt + 1'b1;
          end else begin
            half_cnt <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
              if (st == LD_DATA) rx <= {rx[6:0], miso};
            end else begin
              sclk   <= 1'b0;
              tx     <= {tx[HDR_BITS-2:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
              if (st == LD_CMD && bitcnt == 5'd31) begin
                st     <= LD_DATA;
                bitcnt <= '0;
              end else if (st == LD_DATA && bitcnt[2:0] == 3'd7) begin
                we    <= 1'b1;
                waddr <= baddr;
                wdata <= rx;
                baddr <= baddr + 1'b1;
                if (baddr == LAST) begin
                  st   <= LD_DONE;
                  cs_n <= 1'b1;
                end
              end
            end
          end
        end
        default: done <= 1'b1;
      endcase
    end
  end

  // R8: the serial clock never runs while the flash is deselected
  a_r8_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  // R2: MOSI is held steady across every high phase of the serial clock
  a_r2_mosi_mode0: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R3: table writes happen only inside an active transfer
  a_r3_write_in_window: assert property (@(posedge clk) disable iff (rst)
    we |-> (!cs_n || st == LD_DONE));
endmodule

// File: rtl/remap_table_ram.sv
module remap_table_ram #(
  parameter int ADDR_W = 10,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic              lookup_en,
  input  logic [ADDR_W-1:0] raddr,
  input  logic [DW-1:0]     bypass,
  output logic [DW-1:0]     rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= lookup_en ? mem[raddr] : bypass;
  end
endmodule

// File: rtl/remap_lut_bridge.sv
module remap_lut_bridge
  import remap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTRL_W = 2,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [DATA_W-1:0] dout,
  output logic              ready,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int AW = CTRL_W + DATA_W;

  logic          ld_we;
  logic [AW-1:0] ld_waddr;
  logic [7:0]    ld_wdata;
  logic          ld_done;

  remap_spi_loader #(.DIV(DIV), .ADDR_W(AW)) u_loader (
    .clk   (clk),
    .rst   (rst),
    .sclk  (spi_sclk),
    .cs_n  (spi_cs_n),
    .mosi  (spi_mosi),
    .miso  (spi_miso),
    .we    (ld_we),
    .waddr (ld_waddr),
    .wdata (ld_wdata),
    .done  (ld_done)
  );

  remap_table_ram #(.ADDR_W(AW), .DW(DATA_W)) u_table (
    .clk       (clk),
    .we        (ld_we),
    .waddr     (ld_waddr),
    .wdata     (ld_wdata[DATA_W-1:0]),
    .lookup_en (ld_done),
    .raddr     ({ctrl, din}),
    .bypass    (din),
    .rdata     (dout)
  );

  assign ready = ld_done;

  // R5: pass-through while the table is still filling
  a_r5_passthrough: assert property (@(posedge clk) disable iff (rst)
    !ready |=> (dout == $past(din)));
  // R4: ready never drops without a reset
  a_r4_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
  // R4: flash released once loaded
  a_r4_released: assert property (@(posedge clk) disable iff (rst)
    ready |-> (spi_cs_n && !spi_sclk));
  // R1: reset state at the pins
  always @(posedge clk) begin
    if ($past(rst)) begin
      a_r1_reset_state: assert (!ready && spi_cs_n && !spi_sclk);
    end
  end
endmodule

// File: tb/remap_lut_bridge_test.sv
module remap_lut_bridge_test;
  localparam int DATA_W = 8;
  localparam int CTRL_W = 2;
  localparam int DIV    = 4;
  localparam int NENT   = 1 << (CTRL_W + DATA_W);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DATA_W-1:0] din = '0;
  logic [CTRL_W-1:0] ctrl = '0;
  logic [DATA_W-1:0] dout;
  logic ready, spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  remap_lut_bridge #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .DIV(DIV)) uut (
    .clk(clk), .rst(rst), .din(din), .ctrl(ctrl), .dout(dout), .ready(ready),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] tbl(int a);
    return 8'((a * 37) ^ (a >> 2) ^ 8'h5A);
  endfunction

  // flash model
  int rises = 0;
  int last_session = -1;
  int last_rise = 0;
  int per_bad = 0;
  logic [31:0] hdr = '0;

  always @(negedge spi_cs_n) begin
    rises = 0;
    hdr   = '0;
  end
  always @(posedge spi_cs_n) last_session = rises;
  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      if (rises < 32) hdr = {hdr[30:0], spi_mosi};
      if (rises > 0 && (cyc - last_rise) != DIV) per_bad = per_bad + 1;
      last_rise = cyc;
      rises = rises + 1;
    end
  end
  always @(negedge spi_sclk) begin
    if (!spi_cs_n && rises >= 32) begin
      int idx;
      idx = rises - 32;
      spi_miso = tbl(idx / 8)[7 - (idx % 8)];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ready(input int limit);
    int n = 0;
    while (!ready && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!ready && spi_cs_n && !spi_sclk, "R1", {ready, spi_cs_n, spi_sclk}, 3'b010);
  endtask

  task automatic t_passthrough;
    for (int i = 0; i < 6; i++) begin
      din  = 8'(8'h3C + i * 41);
      ctrl = 2'(i);
      @(negedge clk);
      check(!ready && dout == din, "R5", dout, din);
    end
  endtask

  task automatic t_abort;
    int n = 0;
    while (rises < 32 + 8 * 5 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(spi_cs_n && !ready, "R9", {spi_cs_n, ready}, 2'b10);
    rst = 1'b0;
  endtask

  task automatic t_header;
    int n = 0;
    while (rises < 33 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(hdr == 32'h0300_0000, "R2", hdr, 32'h0300_0000);
  endtask

  task automatic t_load_done;
    wait_ready(3 * NENT * DIV * 8 + 1000);
    check(ready == 1'b1, "R4", ready, 1);
    check(spi_cs_n && !spi_sclk, "R4", {spi_cs_n, spi_sclk}, 2'b10);
    check(last_session == 32 + 8 * NENT, "R3", last_session, 32 + 8 * NENT);
    check(per_bad == 0, "R8", per_bad, 0);
  endtask

  task automatic t_sweep;
    int exp_v;
    @(negedge clk);
    ctrl = '0; din = '0;
    exp_v = tbl(0);
    for (int a = 1; a <= NENT; a++) begin
      @(negedge clk);
      check(dout == 8'(exp_v), "R6", dout, exp_v);
      if (a < NENT) begin
        {ctrl, din} = (CTRL_W + DATA_W)'(a);
        exp_v = tbl(a);
      end
    end
  endtask

  task automatic t_stateless;
    logic [7:0] first;
    ctrl = 2'd1; din = 8'h00; @(negedge clk);
    ctrl = 2'd2; din = 8'hA5; @(negedge clk);
    first = dout;
    ctrl = 2'd3; din = 8'hFF; @(negedge clk);
    ctrl = 2'd2; din = 8'hA5; @(negedge clk);
    check(dout == first && first == tbl(2 * 256 + 8'hA5), "R7", dout, first);
    repeat (4) @(negedge clk);
    check(dout == tbl(2 * 256 + 8'hA5) && ready, "R7", dout, tbl(2 * 256 + 8'hA5));
  endtask

  initial begin
    fork
      begin
        #1ms;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    @(negedge clk);
    t_reset;
    rst = 1'b0;
    t_passthrough;
    t_abort;
    t_header;
    t_passthrough;
    t_load_done;
    check(per_bad == 0 && spi_cs_n && !spi_sclk, "R8", per_bad, 0);
    t_sweep;
    t_stateless;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule